// File: doc/BRIEF.md
# Exception Acceptance and Block Controller

This block sits at the instruction boundary of a processor pipeline. In each cycle that marks a boundary, it decides whether a pending exception is taken. When one is taken, it raises an accept strobe, selects the handler vector, and records the return address in a saved-PC register. It also owns the block mask bit that suppresses exception acceptance while a handler runs. The mask is set on every acceptance. A one-cycle clear input lowers the mask, standing in for handler software.

Three request kinds arrive: an asynchronous DMA address error pulse, an asynchronous user break pulse, and a synchronous exception flag bound to the current instruction. The flag carries a type bit that marks it as either re-execution or completion. While the mask is set, the three kinds are handled differently:
- A DMA error is latched and taken later.
- A user break is thrown away.
- A synchronous exception becomes a multiple exception, which is steered to the reset vector without touching the saved PC.

The return address depends on the exception type and on the delayed-branch status. It can be the current instruction, the next instruction, the delayed branch itself, or the branch target.

Top module: `excAcceptTop`

## Requirements
- R1: After reset the mask reads 1, the accept strobe is 0 and the saved PC reads 0.
- R2: A one-cycle clear pulse sets the mask to 0 on the next cycle. An acceptance sets the mask to 1 on the next cycle, even if a clear pulse arrives in the same cycle. The set-mask request output equals the accept strobe in every cycle.
- R3: A DMA error pulse that is not accepted at once is held pending, for as long as needed. It is accepted at the first boundary where the mask is 0. It is accepted exactly once.
- R4: A user break that is not accepted in the cycle it arrives is discarded. Clearing the mask later must not lead to its acceptance.
- R5: A synchronous exception at a boundary while the mask is 1 is a multiple exception. In that cycle the accept strobe is 1, the multiple flag is 1, the vector select is 1 and the vector address is 0xA0000000. The saved PC keeps its previous value.
- R6: A re-execution exception outside a delay slot saves the current instruction address.
- R7: A re-execution exception in a delay slot saves the address of the delayed branch, so that both the branch and its slot re-execute.
- R8: A completion exception saves the address of the next instruction. If the instruction is a delayed branch or sits in a delay slot, it saves the branch target address instead.
- R9: When several requests are eligible at once, the order is: pending DMA error first, then the synchronous exception, then the user break. A losing user break is discarded.
- R10: An accepted DMA error or user break saves a return address by the same rule as a completion exception.
- R11: Nothing is accepted in a cycle that is not an instruction boundary. A DMA error that arrives in such a cycle still becomes pending.
- R12: A normal acceptance drives vector select 0 and the general vector address parameter. The saved PC is updated on the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| blClear | input | 1 | One-cycle request to lower the mask |
| dmaErr | input | 1 | DMA address error pulse |
| userBreak | input | 1 | User break pulse |
| instValid | input | 1 | This cycle is an instruction boundary |
| syncExc | input | 1 | Synchronous exception raised by the current instruction |
| syncReexec | input | 1 | 1 = re-execution type, 0 = completion type |
| inSlot | input | 1 | Current instruction is in a delay slot |
| inBranch | input | 1 | Current instruction is a delayed branch |
| curPc | input | PC_W | Address of current instruction |
| nextPc | input | PC_W | Address of following instruction |
| branchPc | input | PC_W | Address of the delayed branch owning the slot |
| targetPc | input | PC_W | Delayed-branch target address |
| accept | output | 1 | Exception taken this cycle |
| multiExc | output | 1 | Taken exception is a multiple exception |
| vecSel | output | 1 | 0 = general vector, 1 = reset vector |
| vecAddr | output | PC_W | Selected vector address |
| blSetReq | output | 1 | Request to set the mask |
| blMask | output | 1 | Current mask state |
| savedPc | output | PC_W | Saved return address |

## Verification
Several events can coincide at one boundary:
- A pending DMA error can meet a synchronous exception and a user break.
- A clear pulse can meet an acceptance.

The bench sweeps every combination of these:
- mask state
- pending DMA error
- synchronous flag and its type
- delay-slot and delayed-branch status
- user break

For each combination, the bench computes the winner, the vector and the saved address arithmetically. It then clears the mask and offers an empty boundary. This shows whether a masked DMA error was kept and whether a masked user break was wrongly kept. A directed case raises clear and acceptance together and expects the mask to stay 1.

// File: rtl/excPkg.sv
package excPkg;
  typedef enum logic [1:0] {
    PC_CUR    = 2'd0,
    PC_NEXT   = 2'd1,
    PC_BRANCH = 2'd2,
    PC_TARGET = 2'd3
  } pcSelT;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DMA  = 2'd1,
    SRC_SYNC = 2'd2,
    SRC_UB   = 2'd3
  } srcT;

  typedef struct packed {
    logic  loadPc;
    pcSelT pcSel;
    logic  vecSel;
  } ctrlStrobeT;
endpackage

// File: rtl/excCtrl.sv
module excCtrl
  import excPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       blClear,
  input  logic       dmaErr,
  input  logic       userBreak,
  input  logic       instValid,
  input  logic       syncExc,
  input  logic       syncReexec,
  input  logic       inSlot,
  input  logic       inBranch,
  output logic       accept,
  output logic       multiExc,
  output logic       blSetReq,
  output logic       blMask,
  output ctrlStrobeT strobe
);
  logic bl;
  logic dmaPend;
  logic dmaReq;
  srcT  src;

  assign dmaReq = dmaPend | dmaErr;

  // Arbitration at the boundary: DMA, then synchronous, then user break.
  always_comb begin
    src      = SRC_NONE;
    multiExc = 1'b0;
    if (instValid) begin
      if (!bl) begin
        if (dmaReq)         src = SRC_DMA;
        else if (syncExc)   src = SRC_SYNC;
        else if (userBreak) src = SRC_UB;
      end else if (syncExc) begin
        multiExc = 1'b1;
      end
    end
  end

  assign accept   = (src != SRC_NONE) | multiExc;
  assign blSetReq = accept;
  assign blMask   = bl;

  always_comb begin
    strobe.loadPc = (src != SRC_NONE);
    strobe.vecSel = multiExc;
    if (src == SRC_SYNC && syncReexec)
      strobe.pcSel = inSlot ? PC_BRANCH : PC_CUR;
    else
      strobe.pcSel = (inSlot | inBranch) ? PC_TARGET : PC_NEXT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bl      <= 1'b1;
      dmaPend <= 1'b0;
    end else begin
      if (accept)       bl <= 1'b1;
      else if (blClear) bl <= 1'b0;
      if (src == SRC_DMA) dmaPend <= 1'b0;
      else if (dmaErr)    dmaPend <= 1'b1;
    end
  end

  // R2: acceptance always leaves the mask raised
  a_r2_accept_sets_bl: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> blMask);
  // R3: masked DMA error is retained
  a_r3_dma_held: assert property (@(posedge clk) disable iff (!rstN)
    (dmaErr && bl) |=> dmaPend);
  // R4: no normal acceptance while masked
  a_r4_no_take_masked: assert property (@(posedge clk) disable iff (!rstN)
    bl |-> !(accept && !multiExc));
  // R5: multiple exception only under mask and uses reset vector
  a_r5_multi_vector: assert property (@(posedge clk) disable iff (!rstN)
    multiExc |-> (blMask && strobe.vecSel && !strobe.loadPc));
  // R11: nothing outside a boundary
  a_r11_boundary_only: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> !accept);
endmodule

// File: rtl/excPath.sv
module excPath
  import excPkg::*;
#(
  parameter int              PC_W    = 32,
  parameter logic [PC_W-1:0] GEN_VEC = 32'h8000_0100,
  parameter logic [PC_W-1:0] RST_VEC = 32'hA000_0000
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobeT      strobe,
  input  logic [PC_W-1:0] curPc,
  input  logic [PC_W-1:0] nextPc,
  input  logic [PC_W-1:0] branchPc,
  input  logic [PC_W-1:0] targetPc,
  output logic [PC_W-1:0] vecAddr,
  output logic [PC_W-1:0] savedPc
);
  logic [PC_W-1:0] pcMux;

  always_comb begin
    unique case (strobe.pcSel)
      PC_CUR:    pcMux = curPc;
      PC_NEXT:   pcMux = nextPc;
      PC_BRANCH: pcMux = branchPc;
      default:   pcMux = targetPc;
    endcase
  end

  assign vecAddr = strobe.vecSel ? RST_VEC : GEN_VEC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              savedPc <= '0;
    else if (strobe.loadPc) savedPc <= pcMux;
  end

  // R5: saved PC untouched when no normal acceptance
  a_r5_pc_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadPc |=> $stable(savedPc));
  // R12: load lands on the following cycle
  a_r12_pc_loaded: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPc |=> (savedPc == $past(pcMux)));
endmodule

// File: rtl/excAcceptTop.sv
module excAcceptTop
  import excPkg::*;
#(
  parameter int              PC_W    = 32,
  parameter logic [PC_W-1:0] GEN_VEC = 32'h8000_0100,
  parameter logic [PC_W-1:0] RST_VEC = 32'hA000_0000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            blClear,
  input  logic            dmaErr,
  input  logic            userBreak,
  input  logic            instValid,
  input  logic            syncExc,
  input  logic            syncReexec,
  input  logic            inSlot,
  input  logic            inBranch,
  input  logic [PC_W-1:0] curPc,
  input  logic [PC_W-1:0] nextPc,
  input  logic [PC_W-1:0] branchPc,
  input  logic [PC_W-1:0] targetPc,
  output logic            accept,
  output logic            multiExc,
  output logic            vecSel,
  output logic [PC_W-1:0] vecAddr,
  output logic            blSetReq,
  output logic            blMask,
  output logic [PC_W-1:0] savedPc
);
  ctrlStrobeT strobe;

  excCtrl uCtrl (
    .clk(clk), .rstN(rstN), .blClear(blClear), .dmaErr(dmaErr),
    .userBreak(userBreak), .instValid(instValid), .syncExc(syncExc),
    .syncReexec(syncReexec), .inSlot(inSlot), .inBranch(inBranch),
    .accept(accept), .multiExc(multiExc), .blSetReq(blSetReq),
    .blMask(blMask), .strobe(strobe)
  );

  excPath #(.PC_W(PC_W), .GEN_VEC(GEN_VEC), .RST_VEC(RST_VEC)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curPc(curPc),
    .nextPc(nextPc), .branchPc(branchPc), .targetPc(targetPc),
    .vecAddr(vecAddr), .savedPc(savedPc)
  );

  assign vecSel = strobe.vecSel;
endmodule

// File: tb/excAcceptTop_test.sv
module excAcceptTop_test;
  localparam logic [31:0] CUR = 32'h0000_1000, NXT = 32'h0000_1002;
  localparam logic [31:0] BRP = 32'h0000_0FFE, TGT = 32'h0000_2000;
  localparam logic [31:0] GENV = 32'h8000_0100, RSTV = 32'hA000_0000;

  logic clk = 0, rstN = 0;
  logic blClear = 0, dmaErr = 0, userBreak = 0, instValid = 0;
  logic syncExc = 0, syncReexec = 0, inSlot = 0, inBranch = 0;
  logic accept, multiExc, vecSel, blSetReq, blMask;
  logic [31:0] vecAddr, savedPc;
  int nChecks = 0, nErr = 0;

  always #5 clk = ~clk;

  excAcceptTop uut (
    .clk(clk), .rstN(rstN), .blClear(blClear), .dmaErr(dmaErr),
    .userBreak(userBreak), .instValid(instValid), .syncExc(syncExc),
    .syncReexec(syncReexec), .inSlot(inSlot), .inBranch(inBranch),
    .curPc(CUR), .nextPc(NXT), .branchPc(BRP), .targetPc(TGT),
    .accept(accept), .multiExc(multiExc), .vecSel(vecSel),
    .vecAddr(vecAddr), .blSetReq(blSetReq), .blMask(blMask),
    .savedPc(savedPc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearIns();
    blClear = 0; dmaErr = 0; userBreak = 0; instValid = 0;
    syncExc = 0; syncReexec = 0; inSlot = 0; inBranch = 0;
  endtask

  task automatic doReset();
    @(negedge clk); clearIns(); rstN = 0;
    @(negedge clk); @(negedge clk); rstN = 1;
  endtask

  task automatic pulseClear();
    @(negedge clk); blClear = 1;
    @(negedge clk); blClear = 0;
  endtask

  initial begin
    #1_000_000;
    nErr++; nChecks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    // R1: reset state
    doReset();
    #1;
    chk("R1 mask", 32'(blMask), 1);
    chk("R1 accept", 32'(accept), 0);
    chk("R1 savedPc", savedPc, 0);

    // R2: clear lowers mask; accept and clear together keep it high
    pulseClear();
    #1 chk("R2 mask cleared", 32'(blMask), 0);
    @(negedge clk); instValid = 1; syncExc = 1; blClear = 1;
    #1 chk("R2 setReq", 32'(blSetReq), 1);
    @(negedge clk); clearIns();
    #1 chk("R2 mask set wins", 32'(blMask), 1);

    // R11: no acceptance off-boundary; DMA still becomes pending
    pulseClear();
    @(negedge clk); userBreak = 1; syncExc = 1; dmaErr = 1;
    #1 chk("R11 no accept", 32'(accept), 0);
    @(negedge clk); clearIns(); instValid = 1;
    #1 chk("R11 dma pending taken", 32'(accept), 1);
    @(negedge clk); clearIns();
    // R3: exactly once
    pulseClear();
    @(negedge clk); instValid = 1;
    #1 chk("R3 taken once", 32'(accept), 0);
    @(negedge clk); clearIns();

    // Sweep all combinations
    for (int c = 0; c < 128; c++) begin
      logic wBl, wDma, wSync, wRe, wSlot, wBr, wUb, eMulti, eAcc;
      int src;
      logic [31:0] ePc;
      string pcReq;
      wBl = c[0]; wDma = c[1]; wSync = c[2]; wRe = c[3];
      wSlot = c[4]; wBr = c[5]; wUb = c[6];
      src = 0; eMulti = 0;
      if (!wBl) begin
        if (wDma) src = 1; else if (wSync) src = 2; else if (wUb) src = 3;
      end else eMulti = wSync;
      eAcc = (src != 0) || eMulti;
      if (src == 2 && wRe) begin
        ePc = wSlot ? BRP : CUR;
        pcReq = wSlot ? "R7" : "R6";
      end else begin
        ePc = (wSlot || wBr) ? TGT : NXT;
        pcReq = (src == 2) ? "R8" : "R10";
      end
      if (src == 0) begin ePc = 0; pcReq = "R5"; end

      doReset();
      if (wDma) begin
        @(negedge clk); dmaErr = 1;
        @(negedge clk); dmaErr = 0;
      end
      if (!wBl) pulseClear();
      @(negedge clk);
      instValid = 1; syncExc = wSync; syncReexec = wRe;
      inSlot = wSlot; inBranch = wBr; userBreak = wUb;
      #1;
      chk("R9 accept", 32'(accept), 32'(eAcc));
      chk("R5 multi", 32'(multiExc), 32'(eMulti));
      chk("R2 setReq", 32'(blSetReq), 32'(eAcc));
      if (eAcc) begin
        chk("R12 vecSel", 32'(vecSel), 32'(eMulti));
        chk("R12 vecAddr", vecAddr, eMulti ? RSTV : GENV);
      end
      @(negedge clk); clearIns();
      #1;
      chk(pcReq, savedPc, ePc);
      chk("R2 mask", 32'(blMask), 32'(wBl || eAcc));
      blClear = 1;
      @(negedge clk); blClear = 0; instValid = 1;
      #1;
      // R3 retained masked DMA; R4 masked user break not retained
      chk((wDma && wBl) ? "R3 late dma" : "R4 nothing late", 32'(accept),
          32'(wDma && wBl));
      @(negedge clk); clearIns();
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule